// File: doc/BRIEF.md
# Byte-Framed Serial Slave Port

This block is the serial front end of a register-based peripheral. It is a full-duplex slave on four wires: an active-low select, a serial clock, serial data in and serial data out. All four wires are sampled by a faster system clock, which must run at least four times the serial clock rate. Their edges are found from synchronized copies, so all logic sits in the system clock domain. Each word is eight bits long and travels most significant bit first. Incoming bits are sampled on falling serial-clock edges. Outgoing bits change on rising edges.

When select falls, the block loads a status byte into its shift register. In the same step it drives the serial output with the OR of its transmission-error flag and the present serial input level. Any device further down a daisy chain therefore shows an earlier failed transfer as a high level. Falling clock edges are counted modulo eight. When select rises, the frame is accepted only if a nonzero whole number of bytes was clocked in. In that case the last byte received is presented as a write request. Its bits [7:6] are the command code, bits [5:4] the register address and bits [3:0] the data. Any other count sets the error flag and discards the frame. Because bits pass straight through the shift register, devices can be chained.

The write request leaves on a valid/ready handshake. `wr_valid` stays high, with command, address and data unchanged, until the cycle in which `wr_ready` is also high. A frame that completes while a request is still pending is dropped. Such a frame still counts as correctly framed for the error flag. The consumer must therefore accept each request within one frame time.

Top module: `spi_fc_slave`

## Requirements
- R1: While select is high, `spi_so_oe` is low. Serial clock and data activity cause no write request and leave `tx_err` unchanged.
- R2: A few system cycles after select falls, `spi_so_oe` goes high and `spi_so` equals `tx_err` OR the serial input level. This value holds until the first rising serial-clock edge.
- R3: On each of the first eight rising serial-clock edges, `spi_so` presents the status byte captured at select fall, bit 7 first.
- R4: Serial input is sampled on falling serial-clock edges and shifted in most significant bit first.
- R5: When select rises after a nonzero multiple of 8 falling edges, exactly one write request is issued. It carries the last 8 bits received, with `wr_cmd`=bits[7:6], `wr_addr`=bits[5:4] and `wr_data`=bits[3:0].
- R6: When select rises after a count that is zero or not a multiple of 8, `tx_err` becomes 1 and no write request is issued.
- R7: `tx_err` returns to 0 when a correctly framed access completes.
- R8: From the ninth rising edge of a frame on, `spi_so` carries the bit received on serial input eight clocks earlier (daisy chain).
- R9: `wr_valid` stays high with a stable payload until `wr_ready` is high. A frame that completes while a request is pending leaves the pending payload untouched.
- R10: After reset, `spi_so_oe`, `wr_valid` and `tx_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sclk | input | 1 | Serial clock, low when select changes |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the serial data out pad |
| status_i | input | 8 | Status byte returned in each frame |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Consumer accepts the write request |
| wr_cmd | output | 2 | Command code of the request |
| wr_addr | output | 2 | Register address of the request |
| wr_data | output | 4 | Data of the request |
| tx_err | output | 1 | Transmission error flag |

## Verification
The hardest state to reach from the ports is a correctly framed frame that completes while an earlier request is still waiting. This is the only way to see whether a pending payload can be overwritten. The stimulus holds `wr_ready` low across two full legal frames with different bytes. It then checks that the first byte is still presented, and releases ready only after that check. The error-flag path is driven in a similar way. A sweep of frame lengths from 0 to 17 bits leaves the flag set before the next frame, so that the select-fall value on `spi_so` can be seen with both the flag and the serial input low and high.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;
  localparam int CMD_W  = 2;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 4;
  localparam int WORD_W = CMD_W + ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } spi_word_t;
endpackage

// File: rtl/spi_fc_sync.sv
module spi_fc_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = STAGES * WIDTH;
  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spi_fc_shifter.sv
module spi_fc_shifter
  import spi_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,      // select fell
  input  logic              stop,       // select rose
  input  logic              start_val,  // value driven at frame start
  input  logic [WORD_W-1:0] load_val,   // status byte
  input  logic              out_edge,   // rising serial clock
  input  logic              in_edge,    // falling serial clock
  input  logic              in_bit,
  output logic [WORD_W-1:0] word,
  output logic              so,
  output logic              oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      so   <= 1'b0;
      oe   <= 1'b0;
    end else begin
      if (start) begin
        word <= load_val;
        so   <= start_val;
        oe   <= 1'b1;
      end else if (stop) begin
        oe   <= 1'b0;
      end else begin
        if (out_edge) so   <= word[WORD_W-1];
        if (in_edge)  word <= {word[WORD_W-2:0], in_bit};
      end
    end
  end

  assert_start_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (oe && so == $past(start_val)));
  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !oe);
endmodule

// File: rtl/spi_fc_framer.sv
module spi_fc_framer
  import spi_fc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic in_edge,
  output logic frame_ok,
  output logic err
);
  logic [CNT_W-1:0] cnt;
  logic             seen_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      seen_word <= 1'b0;
    end else if (start) begin
      cnt       <= '0;
      seen_word <= 1'b0;
    end else if (in_edge) begin
      if (cnt == CNT_W'(WORD_W-1)) begin
        cnt       <= '0;
        seen_word <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_ok = stop && seen_word && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err <= 1'b0;
    else if (stop)     err <= !frame_ok;
  end

  assert_partial_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && cnt != '0) |=> err);
  assert_empty_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !seen_word) |=> err);
  assert_count_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0 && !seen_word));
endmodule

// File: rtl/spi_fc_wrport.sv
module spi_fc_wrport
  import spi_fc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  spi_word_t word_in,
  output logic      valid,
  input  logic      ready,
  output spi_word_t word_out
);
  logic pending;
  assign pending = valid && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      word_out <= '0;
    end else if (accept && !pending) begin
      valid    <= 1'b1;
      word_out <= word_in;
    end else if (valid && ready) begin
      valid    <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(word_out)));
  assert_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !valid) |=> (valid && word_out == $past(word_in)));
endmodule

// File: rtl/spi_fc_slave.sv
module spi_fc_slave
  import spi_fc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic [WORD_W-1:0] status_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [CMD_W-1:0]  wr_cmd,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              tx_err
);
  logic cs_s, sclk_s, si_s;
  logic cs_q, sclk_q;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic frame_ok;
  logic [WORD_W-1:0] shift_word;
  spi_word_t wr_word;

  spi_fc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sclk, spi_si}),
    .q({cs_s, sclk_s, si_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign cs_fall   = cs_q && !cs_s;
  assign cs_rise   = !cs_q && cs_s;
  assign sclk_rise = !cs_s && !cs_q && sclk_s && !sclk_q;
  assign sclk_fall = !cs_s && !cs_q && !sclk_s && sclk_q;

  spi_fc_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(cs_fall), .stop(cs_rise),
    .start_val(tx_err | si_s),
    .load_val(status_i),
    .out_edge(sclk_rise), .in_edge(sclk_fall), .in_bit(si_s),
    .word(shift_word), .so(spi_so), .oe(spi_so_oe)
  );

  spi_fc_framer u_frame (
    .clk(clk), .rst_n(rst_n),
    .start(cs_fall), .stop(cs_rise), .in_edge(sclk_fall),
    .frame_ok(frame_ok), .err(tx_err)
  );

  spi_fc_wrport u_wr (
    .clk(clk), .rst_n(rst_n),
    .accept(frame_ok), .word_in(spi_word_t'(shift_word)),
    .valid(wr_valid), .ready(wr_ready), .word_out(wr_word)
  );

  assign wr_cmd  = wr_word.cmd;
  assign wr_addr = wr_word.addr;
  assign wr_data = wr_word.data;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_q) |=> (!spi_so_oe && !$rose(wr_valid) && $stable(tx_err)));
  assert_good_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !tx_err);
endmodule

// File: tb/spi_fc_slave_tb.sv
module spi_fc_slave_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic [7:0] status = 8'h00;
  logic wr_valid, wr_ready = 1'b1;
  logic [1:0] wr_cmd, wr_addr;
  logic [3:0] wr_data;
  logic tx_err;

  int n_checks = 0, n_err = 0, hs_cnt = 0;
  logic [7:0] hs_word = 8'h00;
  logic err_m = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_fc_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe), .status_i(status),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_cmd(wr_cmd), .wr_addr(wr_addr), .wr_data(wr_data), .tx_err(tx_err)
  );

  always @(negedge clk) begin
    if (wr_valid && wr_ready) begin
      hs_cnt  <= hs_cnt + 1;
      hs_word <= {wr_cmd, wr_addr, wr_data};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends n bits of tx, bit tx[n-1] first, and checks SO throughout.
  task automatic frame(input int n, input logic [23:0] tx);
    logic [23:0] got = '0;
    logic [23:0] exp_so = '0;
    logic si0;
    int hs0;
    si0 = (n > 0) ? tx[n-1] : 1'b0;
    si = si0;
    wait_cyc(1);
    cs_n = 1'b0;
    wait_cyc(HALF);
    chk(so_oe && (so == (err_m | si0)), "R2 start value", {so_oe, so}, {1'b1, err_m | si0});
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      si = tx[n-1-i];
      wait_cyc(HALF);
      got[i] = so;
      exp_so[i] = (i < 8) ? status[7-i] : tx[n-1-(i-8)];
      sclk = 1'b0;
      wait_cyc(HALF);
    end
    if (n > 0) chk(got == exp_so, (n > 8) ? "R3/R8 SO stream" : "R3 SO stream", got, exp_so);
    hs0 = hs_cnt;
    cs_n = 1'b1;
    wait_cyc(10);
    chk(!so_oe, "R1 release", so_oe, 0);
    err_m = !(n > 0 && (n % 8) == 0);
    chk(tx_err == err_m, err_m ? "R6 flag set" : "R7 flag clear", tx_err, err_m);
    if (wr_ready) begin
      if (!err_m) begin
        chk(hs_cnt == hs0 + 1 && hs_word == tx[7:0], "R5/R4 write payload", hs_word, tx[7:0]);
      end else begin
        chk(hs_cnt == hs0, "R6 no write", hs_cnt - hs0, 0);
      end
    end
  endtask

  initial begin
    wait_cyc(3);
    chk(!so_oe && !wr_valid && !tx_err, "R10 reset", {so_oe, wr_valid, tx_err}, 0);
    rst_n = 1'b1;
    wait_cyc(3);

    // R4/R5/R3: every byte, status derived from it
    for (int b = 0; b < 256; b++) begin
      status = 8'(b * 37 + 11);
      frame(8, 24'(b));
    end

    // R6/R7/R8/R2: frame lengths 0..17
    for (int n = 0; n < 18; n++) begin
      status = 8'(8'hC3 ^ n);
      frame(n, 24'(24'h5A3C96 ^ (n * 24'h1357)));
    end

    // R2 with flag set and SI low: error must appear alone
    frame(5, 24'h0000_05);
    frame(8, 24'h0000_7E);  // starts with SI=0 while err=1
    frame(16, 24'h0081_E4);

    // R1: activity while select high
    begin
      int hs0;
      logic e0;
      hs0 = hs_cnt;
      e0 = tx_err;
      for (int k = 0; k < 10; k++) begin
        sclk = ~sclk;
        si = k[0];
        wait_cyc(HALF);
        chk(!so_oe, "R1 idle oe", so_oe, 0);
      end
      sclk = 1'b0;
      wait_cyc(HALF);
      chk(hs_cnt == hs0 && tx_err == e0, "R1 ignored", {hs_cnt - hs0, 31'(tx_err)}, {0, 31'(e0)});
    end

    // R9: back-pressure
    wr_ready = 1'b0;
    frame(8, 24'h0000_A6);
    chk(wr_valid && {wr_cmd, wr_addr, wr_data} == 8'hA6, "R9 pending", {wr_valid, wr_cmd, wr_addr, wr_data}, 9'h1A6);
    frame(8, 24'h0000_3B);
    chk(wr_valid && {wr_cmd, wr_addr, wr_data} == 8'hA6, "R9 kept", {wr_cmd, wr_addr, wr_data}, 8'hA6);
    begin
      int hs0;
      hs0 = hs_cnt;
      wr_ready = 1'b1;
      wait_cyc(2);
      chk(hs_cnt == hs0 + 1 && hs_word == 8'hA6 && !wr_valid, "R9 drained", hs_word, 8'hA6);
    end
    frame(8, 24'h0000_D2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule